// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block produces the control store address for a microprogrammed control unit. It holds the current microword address in a control address register and updates it on every clock. The update uses three inputs: the next-address select field and the branch target field of the microword now being executed, and four datapath status bits. It also uses the opcode of the instruction that the fetch microcode has just read. The control store, the datapath and instruction fetch are all outside the block. The block's only output toward them is the address.

Six next-address actions are available:
- Step to the following address.
- Jump to the branch target.
- Branch only when a chosen status bit is set.
- Dispatch to the first microword of an instruction's routine, found through a constant opcode mapping table.
- Call a microsubroutine, which saves the return address on a four-entry internal stack.
- Return from a microsubroutine.

Stack misuse never corrupts the stack. A call with the stack full, or a return with it empty, only raises a sticky error flag.

Top module: `useq_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets car to 0, clears stk_err and empties the return stack.
- R2: next_sel = 3'b000 loads car + 1, wrapping from 255 to 0 with the default 8-bit address.
- R3: next_sel = 3'b001 loads br_addr into car.
- R4: next_sel = 3'b010 loads br_addr when status[cond_sel] is 1, and car + 1 otherwise; cond_sel is the index of the tested status bit.
- R5: next_sel = 3'b011 loads the mapped address of opcode. With default parameters this is (64 + 4 * opcode) mod 256.
- R6: next_sel = 3'b110 and 3'b111 act exactly like 3'b000: car + 1, with the stack and stk_err untouched.
- R7: next_sel = 3'b100 (call) pushes car + 1 and loads br_addr. next_sel = 3'b101 (return) pops the newest entry into car. Up to four calls nest in last-in first-out order.
- R8: A call while four entries are held still loads br_addr, sets stk_err and leaves the stack contents unchanged.
- R9: A return with an empty stack loads car + 1, sets stk_err and leaves the stack empty.
- R10: Once set, stk_err stays 1 until reset, whatever next_sel does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| next_sel | input | 3 | Next-address select field of the current microword |
| br_addr | input | 8 | Branch/call target field of the current microword |
| cond_sel | input | 2 | Index of the status bit tested by a conditional branch |
| status | input | 4 | Datapath status bits |
| opcode | input | 4 | Opcode of the fetched instruction |
| car | output | 8 | Current control store address |
| stk_err | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
In two cases a single edge does two things at once:
- A call on a full stack both redirects the address and raises the error flag.
- A return on an empty stack both steps the address and raises the flag.

The bench fills the stack with four nested calls and issues a fifth. Right after that edge it checks that car equals the new target and stk_err is 1. It then unwinds the stack and checks that the four saved addresses come back in reverse order, which shows the overflowing call stored nothing. A further return on the empty stack is judged the same way: car must equal the previous address plus one and the flag must be 1.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [2:0] {
        NA_STEP  = 3'b000,
        NA_JUMP  = 3'b001,
        NA_CBR   = 3'b010,
        NA_MAP   = 3'b011,
        NA_CALL  = 3'b100,
        NA_RET   = 3'b101,
        NA_SPR6  = 3'b110,
        NA_SPR7  = 3'b111
    } na_sel_e;

    // Start address of the routine for a given opcode
    function automatic int unsigned map_entry(input int unsigned base,
                                              input int unsigned stride,
                                              input int unsigned op);
        return base + op * stride;
    endfunction

endpackage

// File: rtl/useq_map_rom.sv
module useq_map_rom #(
    parameter int ADDR_W     = 8,
    parameter int OP_W       = 4,
    parameter int MAP_BASE   = 64,
    parameter int MAP_STRIDE = 4
) (
    input  logic [OP_W-1:0]   opcode,
    output logic [ADDR_W-1:0] map_addr
);
    import useq_pkg::*;

    localparam int N_OPS = 1 << OP_W;

    logic [ADDR_W-1:0] tbl [N_OPS];

    for (genvar i = 0; i < N_OPS; i++) begin : g_entry
        assign tbl[i] = ADDR_W'(map_entry(MAP_BASE, MAP_STRIDE, i));
    end

    assign map_addr = tbl[opcode];

endmodule

// File: rtl/useq_ret_stack.sv
module useq_ret_stack #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [CNT_W-1:0]        cnt;
    } stk_t;

    stk_t s_d, s_q;

    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign top   = s_q.mem[PTR_W'(s_q.cnt - CNT_W'(1))];

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d.cnt = '0;
            s_d.mem = '0;
        end else if (push && !full) begin
            s_d.mem[PTR_W'(s_q.cnt)] = push_data;
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end else if (pop && !empty) begin
            s_d.cnt = s_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    AST_STK_BOUND: assert property (@(posedge clk) disable iff (rst) s_q.cnt <= CNT_W'(DEPTH)); // R8
    AST_STK_GROW: assert property (@(posedge clk) disable iff (rst) (push && !full) |=> s_q.cnt == $past(s_q.cnt) + CNT_W'(1)); // R7
    AST_STK_SHRINK: assert property (@(posedge clk) disable iff (rst) (pop && !empty && !push) |=> s_q.cnt == $past(s_q.cnt) - CNT_W'(1)); // R7
    AST_STK_FULL_HOLD: assert property (@(posedge clk) disable iff (rst) (push && full) |=> $stable(s_q.cnt)); // R8
    AST_STK_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst) (pop && empty && !push) |=> $stable(s_q.cnt)); // R9

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
    parameter int ADDR_W = 8
) (
    input  logic [2:0]        sel,
    input  logic [ADDR_W-1:0] car_cur,
    input  logic [ADDR_W-1:0] br_addr,
    input  logic              cond_bit,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [ADDR_W-1:0] stk_top,
    input  logic              stk_full,
    input  logic              stk_empty,
    output logic [ADDR_W-1:0] car_next,
    output logic [ADDR_W-1:0] ret_addr,
    output logic              push,
    output logic              pop,
    output logic              err_set
);
    import useq_pkg::*;

    na_sel_e sel_e;

    assign sel_e    = na_sel_e'(sel);
    assign ret_addr = car_cur + ADDR_W'(1);

    always_comb begin
        car_next = ret_addr;
        push     = 1'b0;
        pop      = 1'b0;
        err_set  = 1'b0;
        unique case (sel_e)
            NA_JUMP: car_next = br_addr;
            NA_CBR:  car_next = cond_bit ? br_addr : ret_addr;
            NA_MAP:  car_next = map_addr;
            NA_CALL: begin
                car_next = br_addr;
                push     = !stk_full;
                err_set  = stk_full;
            end
            NA_RET: begin
                if (stk_empty) begin
                    err_set = 1'b1;
                end else begin
                    car_next = stk_top;
                    pop      = 1'b1;
                end
            end
            default: car_next = ret_addr;
        endcase
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
    parameter int ADDR_W     = 8,
    parameter int OP_W       = 4,
    parameter int N_STAT     = 4,
    parameter int STK_DEPTH  = 4,
    parameter int MAP_BASE   = 64,
    parameter int MAP_STRIDE = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                next_sel,
    input  logic [ADDR_W-1:0]         br_addr,
    input  logic [$clog2(N_STAT)-1:0] cond_sel,
    input  logic [N_STAT-1:0]         status,
    input  logic [OP_W-1:0]           opcode,
    output logic [ADDR_W-1:0]         car,
    output logic                      stk_err
);
    typedef struct packed {
        logic [ADDR_W-1:0] car;
        logic              err;
    } seq_t;

    seq_t r_d, r_q;

    logic [ADDR_W-1:0] map_addr, stk_top, car_next, ret_addr;
    logic              stk_full, stk_empty, push, pop, err_set, cond_bit;

    assign cond_bit = status[cond_sel];

    useq_map_rom #(
        .ADDR_W(ADDR_W), .OP_W(OP_W),
        .MAP_BASE(MAP_BASE), .MAP_STRIDE(MAP_STRIDE)
    ) u_map (
        .opcode  (opcode),
        .map_addr(map_addr)
    );

    useq_ret_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .pop      (pop),
        .push_data(ret_addr),
        .top      (stk_top),
        .full     (stk_full),
        .empty    (stk_empty)
    );

    useq_next_addr #(.ADDR_W(ADDR_W)) u_nxt (
        .sel      (next_sel),
        .car_cur  (r_q.car),
        .br_addr  (br_addr),
        .cond_bit (cond_bit),
        .map_addr (map_addr),
        .stk_top  (stk_top),
        .stk_full (stk_full),
        .stk_empty(stk_empty),
        .car_next (car_next),
        .ret_addr (ret_addr),
        .push     (push),
        .pop      (pop),
        .err_set  (err_set)
    );

    always_comb begin
        r_d = r_q;
        if (rst) begin
            r_d.car = '0;
            r_d.err = 1'b0;
        end else begin
            r_d.car = car_next;
            r_d.err = r_q.err | err_set;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign car     = r_q.car;
    assign stk_err = r_q.err;

    AST_CAR_STEP: assert property (@(posedge clk) disable iff (rst) next_sel == 3'b000 |=> car == $past(car) + ADDR_W'(1)); // R2
    AST_CAR_JUMP: assert property (@(posedge clk) disable iff (rst) next_sel == 3'b001 |=> car == $past(br_addr)); // R3
    AST_CBR_TAKEN: assert property (@(posedge clk) disable iff (rst) (next_sel == 3'b010 && status[cond_sel]) |=> car == $past(br_addr)); // R4
    AST_CBR_FALL: assert property (@(posedge clk) disable iff (rst) (next_sel == 3'b010 && !status[cond_sel]) |=> car == $past(car) + ADDR_W'(1)); // R4
    AST_SPARE_STEP: assert property (@(posedge clk) disable iff (rst) next_sel[2:1] == 2'b11 |=> car == $past(car) + ADDR_W'(1)); // R6
    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (rst) next_sel == 3'b100 |=> car == $past(br_addr)); // R7
    AST_CALL_FULL_ERR: assert property (@(posedge clk) disable iff (rst) (next_sel == 3'b100 && stk_full) |=> stk_err); // R8
    AST_RET_EMPTY: assert property (@(posedge clk) disable iff (rst) (next_sel == 3'b101 && stk_empty) |=> (stk_err && car == $past(car) + ADDR_W'(1))); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) stk_err |=> stk_err); // R10

endmodule

// File: tb/useq_sequencer_test.sv
module useq_sequencer_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] next_sel = 3'b000;
    logic [7:0] br_addr = 8'h00;
    logic [1:0] cond_sel = 2'b00;
    logic [3:0] status = 4'h0;
    logic [3:0] opcode = 4'h0;
    logic [7:0] car;
    logic       stk_err;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    useq_sequencer uut (
        .clk(clk), .rst(rst), .next_sel(next_sel), .br_addr(br_addr),
        .cond_sel(cond_sel), .status(status), .opcode(opcode),
        .car(car), .stk_err(stk_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] s, input logic [7:0] b,
                        input logic [1:0] cs, input logic [3:0] st,
                        input logic [3:0] op);
        @(negedge clk);
        next_sel = s; br_addr = b; cond_sel = cs; status = st; opcode = op;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; next_sel = 3'b000;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 car", car, 0);
        chk("R1 err", stk_err, 0);
    endtask

    task automatic t_step_jump();
        do_reset();
        step(3'b000, 8'h00, 0, 0, 0); chk("R2 inc", car, 1);
        step(3'b000, 8'h00, 0, 0, 0); chk("R2 inc", car, 2);
        step(3'b001, 8'h33, 0, 0, 0); chk("R3 jump", car, 8'h33);
        step(3'b001, 8'hFF, 0, 0, 0); chk("R3 jump", car, 255);
        step(3'b000, 8'h00, 0, 0, 0); chk("R2 wrap", car, 0);
    endtask

    task automatic t_cond();
        do_reset();
        step(3'b001, 8'h20, 0, 0, 0);
        step(3'b010, 8'h70, 2'd2, 4'b0100, 0); chk("R4 taken", car, 8'h70);
        step(3'b010, 8'h10, 2'd2, 4'b1011, 0); chk("R4 not taken", car, 8'h71);
        step(3'b010, 8'h44, 2'd3, 4'b1000, 0); chk("R4 bit3 taken", car, 8'h44);
        step(3'b010, 8'h99, 2'd0, 4'b1110, 0); chk("R4 bit0 clear", car, 8'h45);
    endtask

    task automatic t_map();
        do_reset();
        step(3'b011, 8'h00, 0, 0, 4'd5);  chk("R5 map op5", car, 64 + 4 * 5);
        step(3'b011, 8'h00, 0, 0, 4'd15); chk("R5 map op15", car, (64 + 4 * 15) % 256);
        step(3'b011, 8'hEE, 0, 0, 4'd0);  chk("R5 map op0", car, 64);
    endtask

    task automatic t_spare();
        do_reset();
        step(3'b001, 8'h50, 0, 0, 0);
        step(3'b100, 8'h80, 0, 0, 0);
        step(3'b110, 8'h11, 0, 4'hF, 4'd3); chk("R6 code6", car, 8'h81);
        step(3'b111, 8'h22, 0, 4'hF, 4'd3); chk("R6 code7", car, 8'h82);
        chk("R6 no err", stk_err, 0);
        step(3'b101, 8'h00, 0, 0, 0); chk("R6 stack intact", car, 8'h51);
    endtask

    task automatic t_call_ret();
        do_reset();
        step(3'b001, 8'h10, 0, 0, 0);
        step(3'b100, 8'h80, 0, 0, 0); chk("R7 call target", car, 8'h80);
        step(3'b000, 8'h00, 0, 0, 0);
        step(3'b101, 8'h00, 0, 0, 0); chk("R7 return", car, 8'h11);
        chk("R7 no err", stk_err, 0);
    endtask

    task automatic t_overflow();
        do_reset();
        step(3'b000, 8'h00, 0, 0, 0);
        step(3'b100, 8'h80, 0, 0, 0);
        step(3'b100, 8'h90, 0, 0, 0);
        step(3'b100, 8'hA0, 0, 0, 0);
        step(3'b100, 8'hB0, 0, 0, 0); chk("R7 4th call", car, 8'hB0);
        chk("R7 full no err", stk_err, 0);
        step(3'b100, 8'hC0, 0, 0, 0); chk("R8 jump on full", car, 8'hC0);
        chk("R8 err set", stk_err, 1);
        step(3'b101, 8'h00, 0, 0, 0); chk("R8 pop1", car, 8'hA1);
        step(3'b101, 8'h00, 0, 0, 0); chk("R8 pop2", car, 8'h91);
        step(3'b101, 8'h00, 0, 0, 0); chk("R8 pop3", car, 8'h81);
        step(3'b101, 8'h00, 0, 0, 0); chk("R7 pop4", car, 8'h02);
        step(3'b101, 8'h00, 0, 0, 0); chk("R9 empty ret inc", car, 8'h03);
        step(3'b000, 8'h00, 0, 0, 0);
        step(3'b001, 8'h05, 0, 0, 0);
        chk("R10 sticky", stk_err, 1);
    endtask

    task automatic t_underflow_reset();
        do_reset();
        step(3'b001, 8'h3C, 0, 0, 0);
        chk("R9 before", stk_err, 0);
        step(3'b101, 8'h00, 0, 0, 0); chk("R9 inc on empty", car, 8'h3D);
        chk("R9 err", stk_err, 1);
        step(3'b100, 8'h60, 0, 0, 0);
        chk("R9 stack still usable", car, 8'h60);
        step(3'b101, 8'h00, 0, 0, 0); chk("R9 push after underflow", car, 8'h3E);
        step(3'b100, 8'h70, 0, 0, 0);
        do_reset();
        chk("R1 car after mid reset", car, 0);
        chk("R10 cleared by reset", stk_err, 0);
        step(3'b101, 8'h00, 0, 0, 0); chk("R1 stack emptied", car, 1);
        chk("R1 stack emptied err", stk_err, 1);
    endtask

    initial begin
        t_reset();
        t_step_jump();
        t_cond();
        t_map();
        t_spare();
        t_call_ret();
        t_overflow();
        t_underflow_reset();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule